// File: doc/BRIEF.md
# Call-Gate Privilege Transition Sequencer

This block carries out the register and stack work of a far call made through a call gate. A caller presents the 64-bit gate descriptor, the requestor privilege of the selector that named it, the current code and stack registers, and the selector of the task-state area. The block checks the gate. When the call moves to a more trusted ring, the block reads the inner ring's stack pointer pair from the task-state area and builds the new stack. The old stack pointer goes on first, then the descriptor-specified parameters, then the return address. It then hands back the new code and stack registers.

A call that stays in the current ring only pushes the return address on the current stack. A gate that fails a check raises a one-cycle fault. That fault makes no memory access and changes no output register. All memory traffic goes through one word-wide port that addresses by segment and offset. Read data is valid on the cycle after the request, with no wait states.

Top module: `callgate_seq`

## Requirements
- R1: After reset, busy, done, fault and mem_req are low, and new_cs, new_ip, new_ss and new_sp are zero.
- R2: The gate type sits in bits 43:40 of the descriptor. Type 0x4 is a 16-bit gate and type 0xC is a 32-bit gate. Any other type is rejected with a fault. A set bit 44 or any set bit in 39:37 is also rejected with a fault.
- R3: A gate is accepted only when all of the following hold. The present bit 47 is 1. The larger of the CPL (cur_cs[1:0]) and gate_rpl is at most the DPL in bits 46:45. The target ring (bits 17:16) is at most CPL. Otherwise fault pulses for one cycle, no memory access is made, and the new_* outputs keep their values.
- R4: For an inward call, the new SP is read as a 16-bit word at offset 2+4*ring of segment tss_sel. The new SS is read at offset 4+4*ring of the same segment.
- R5: An inward call pushes onto the new stack in this order: old SS, old SP, the parameters, old CS, old IP. Each push decrements SP before writing.
- R6: The parameter count is taken from bits 36:32. The parameters are read from the old stack at old SP + i*size. They land on the new stack in the same relative order.
- R7: A 16-bit gate uses 2-byte pushes, zero-extends each value, and takes the entry point from bits 15:0 only. A 32-bit gate uses 4-byte pushes and takes its entry point from bits 63:48 and 15:0.
- R8: When the target ring equals CPL, no task-state read and no parameter copy take place. CS and IP are pushed on the current stack, and SS stays unchanged.
- R9: busy is high from the cycle after an accepted start until the done or fault cycle. done is a one-cycle pulse. In that cycle new_cs holds the gate selector (bits 31:16), new_ip the entry point, and new_ss and new_sp the final stack pointer.
- R10: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gate call (sampled while idle) |
| gate_desc | input | 64 | Call-gate descriptor |
| gate_rpl | input | 2 | Requestor privilege of the gate selector |
| cur_cs | input | 16 | Current code selector (low 2 bits = CPL) |
| cur_ip | input | 32 | Return instruction pointer |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| tss_sel | input | 16 | Segment holding the task-state area |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle rejection pulse |
| new_cs | output | 16 | Resulting code selector |
| new_ip | output | 32 | Resulting instruction pointer |
| new_ss | output | 16 | Resulting stack selector |
| new_sp | output | 32 | Resulting stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | 4-byte access when high, 2-byte when low |
| mem_seg | output | 16 | Access segment |
| mem_off | output | 32 | Access byte offset |
| mem_wdata | output | 32 | Write data (zero-extended when narrow) |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The checker watches the handshake on every cycle. It confirms that done and fault are single-cycle and never coincide, that memory is touched only while busy, that a fault leaves every result register and the memory port untouched, and that busy only drops after done or fault. Only the bench's scenarios show the data path. Those scenarios cover the task-state slot chosen per ring, the exact byte contents and order on the new stack, parameter order, the gate-width effects on step size and entry point, the same-ring shortcut, and each fault reason.

// File: rtl/callgate_pkg.sv
package callgate_pkg;

    localparam int SEL_W = 16;
    localparam int OFF_W = 32;
    localparam int CNT_W = 5;

    localparam logic [3:0] GT_NARROW = 4'h4;
    localparam logic [3:0] GT_WIDE   = 4'hC;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SP,
        ST_RD_SS,
        ST_GOT_SS,
        ST_PUSH_SS,
        ST_PUSH_SP,
        ST_PRM_RD,
        ST_PRM_WR,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic             ok;
        logic             wide;
        logic             same;
        logic [1:0]       tring;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] csel;
        logic [OFF_W-1:0] entry;
    } gate_info_t;

endpackage

// File: rtl/callgate_check.sv
module callgate_check
    import callgate_pkg::*;
(
    input  logic [63:0]      desc,
    input  logic [SEL_W-1:0] cs,
    input  logic [1:0]       rpl,
    output gate_info_t       info
);
    logic       present;
    logic [1:0] dpl;
    logic [3:0] gtype;
    logic [1:0] cpl;
    logic [1:0] eff;
    logic       type_ok;
    logic       priv_ok;

    always_comb begin
        present = desc[47];
        dpl     = desc[46:45];
        gtype   = desc[43:40];
        cpl     = cs[1:0];
        eff     = (cpl > rpl) ? cpl : rpl;
        type_ok = ((gtype == GT_NARROW) || (gtype == GT_WIDE))
                  && !desc[44] && (desc[39:37] == 3'b000);
        priv_ok = (eff <= dpl) && (desc[17:16] <= cpl);

        info.ok    = present && type_ok && priv_ok;
        info.wide  = (gtype == GT_WIDE);
        info.tring = desc[17:16];
        info.same  = (desc[17:16] == cpl);
        info.cnt   = desc[32 +: CNT_W];
        info.csel  = desc[31:16];
        info.entry = info.wide ? {desc[63:48], desc[15:0]} : {16'h0000, desc[15:0]};
    end
endmodule

// File: rtl/callgate_agu.sv
module callgate_agu
    import callgate_pkg::*;
#(
    parameter int SP0_OFF   = 2,
    parameter int SLOT_STEP = 4
) (
    input  logic             wide,
    input  logic [1:0]       tring,
    input  logic [OFF_W-1:0] new_sp,
    input  logic [OFF_W-1:0] old_sp,
    input  logic [CNT_W-1:0] idx,
    output logic [OFF_W-1:0] push_off,
    output logic [OFF_W-1:0] prm_off,
    output logic [OFF_W-1:0] tss_sp_off,
    output logic [OFF_W-1:0] tss_ss_off
);
    localparam logic [OFF_W-1:0] SP0  = OFF_W'(SP0_OFF);
    localparam logic [OFF_W-1:0] SLOT = OFF_W'(SLOT_STEP);

    logic [OFF_W-1:0] step;
    logic [OFF_W-1:0] idx_x;

    always_comb begin
        step       = wide ? OFF_W'(4) : OFF_W'(2);
        idx_x      = OFF_W'(idx);
        push_off   = new_sp - step;
        prm_off    = old_sp + (wide ? (idx_x << 2) : (idx_x << 1));
        tss_sp_off = SP0 + SLOT * OFF_W'(tring);
        tss_ss_off = tss_sp_off + OFF_W'(2);
    end
endmodule

// File: rtl/callgate_seq.sv
module callgate_seq
    import callgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [63:0]      gate_desc,
    input  logic [1:0]       gate_rpl,
    input  logic [SEL_W-1:0] cur_cs,
    input  logic [OFF_W-1:0] cur_ip,
    input  logic [SEL_W-1:0] cur_ss,
    input  logic [OFF_W-1:0] cur_sp,
    input  logic [SEL_W-1:0] tss_sel,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [SEL_W-1:0] new_cs,
    output logic [OFF_W-1:0] new_ip,
    output logic [SEL_W-1:0] new_ss,
    output logic [OFF_W-1:0] new_sp,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [SEL_W-1:0] mem_seg,
    output logic [OFF_W-1:0] mem_off,
    output logic [OFF_W-1:0] mem_wdata,
    input  logic [OFF_W-1:0] mem_rdata
);
    typedef struct packed {
        seq_state_e       state;
        logic             wide;
        logic [1:0]       tring;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] ocs;
        logic [OFF_W-1:0] oip;
        logic [SEL_W-1:0] oss;
        logic [OFF_W-1:0] osp;
        logic [SEL_W-1:0] ncs;
        logic [OFF_W-1:0] nip;
        logic [SEL_W-1:0] nss;
        logic [OFF_W-1:0] nsp;
        logic [SEL_W-1:0] out_cs;
        logic [OFF_W-1:0] out_ip;
        logic [SEL_W-1:0] out_ss;
        logic [OFF_W-1:0] out_sp;
    } seq_regs_t;

    seq_regs_t  r_d, r_q;
    gate_info_t info;

    logic [OFF_W-1:0] push_off, prm_off, tss_sp_off, tss_ss_off;

    callgate_check u_check (
        .desc (gate_desc),
        .cs   (cur_cs),
        .rpl  (gate_rpl),
        .info (info)
    );

    callgate_agu #(.SP0_OFF(2), .SLOT_STEP(4)) u_agu (
        .wide       (r_q.wide),
        .tring      (r_q.tring),
        .new_sp     (r_q.nsp),
        .old_sp     (r_q.osp),
        .idx        (r_q.cnt),
        .push_off   (push_off),
        .prm_off    (prm_off),
        .tss_sp_off (tss_sp_off),
        .tss_ss_off (tss_ss_off)
    );

    function automatic logic [OFF_W-1:0] fit(input logic w, input logic [OFF_W-1:0] v);
        return w ? v : {{(OFF_W-16){1'b0}}, v[15:0]};
    endfunction

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wide  = r_q.wide;
        mem_seg   = '0;
        mem_off   = '0;
        mem_wdata = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.ocs   = cur_cs;
                    r_d.oip   = cur_ip;
                    r_d.oss   = cur_ss;
                    r_d.osp   = cur_sp;
                    r_d.ncs   = info.csel;
                    r_d.nip   = info.entry;
                    r_d.wide  = info.wide;
                    r_d.tring = info.tring;
                    r_d.cnt   = info.cnt;
                    if (!info.ok) begin
                        r_d.state = ST_FAULT;
                    end else if (info.same) begin
                        r_d.nss   = cur_ss;
                        r_d.nsp   = cur_sp;
                        r_d.state = ST_PUSH_CS;
                    end else begin
                        r_d.state = ST_RD_SP;
                    end
                end
            end
            ST_RD_SP: begin
                mem_req   = 1'b1;
                mem_wide  = 1'b0;
                mem_seg   = tss_sel;
                mem_off   = tss_sp_off;
                r_d.state = ST_RD_SS;
            end
            ST_RD_SS: begin
                r_d.nsp   = {{(OFF_W-16){1'b0}}, mem_rdata[15:0]};
                mem_req   = 1'b1;
                mem_wide  = 1'b0;
                mem_seg   = tss_sel;
                mem_off   = tss_ss_off;
                r_d.state = ST_GOT_SS;
            end
            ST_GOT_SS: begin
                r_d.nss   = mem_rdata[SEL_W-1:0];
                r_d.state = ST_PUSH_SS;
            end
            ST_PUSH_SS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_seg   = r_q.nss;
                mem_off   = push_off;
                mem_wdata = OFF_W'(r_q.oss);
                r_d.nsp   = push_off;
                r_d.state = ST_PUSH_SP;
            end
            ST_PUSH_SP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_seg   = r_q.nss;
                mem_off   = push_off;
                mem_wdata = fit(r_q.wide, r_q.osp);
                r_d.nsp   = push_off;
                if (r_q.cnt == '0) begin
                    r_d.state = ST_PUSH_CS;
                end else begin
                    r_d.cnt   = r_q.cnt - 1'b1;
                    r_d.state = ST_PRM_RD;
                end
            end
            ST_PRM_RD: begin
                mem_req   = 1'b1;
                mem_seg   = r_q.oss;
                mem_off   = prm_off;
                r_d.state = ST_PRM_WR;
            end
            ST_PRM_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_seg   = r_q.nss;
                mem_off   = push_off;
                mem_wdata = fit(r_q.wide, mem_rdata);
                r_d.nsp   = push_off;
                if (r_q.cnt == '0) begin
                    r_d.state = ST_PUSH_CS;
                end else begin
                    r_d.cnt   = r_q.cnt - 1'b1;
                    r_d.state = ST_PRM_RD;
                end
            end
            ST_PUSH_CS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_seg   = r_q.nss;
                mem_off   = push_off;
                mem_wdata = OFF_W'(r_q.ocs);
                r_d.nsp   = push_off;
                r_d.state = ST_PUSH_IP;
            end
            ST_PUSH_IP: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_seg    = r_q.nss;
                mem_off    = push_off;
                mem_wdata  = fit(r_q.wide, r_q.oip);
                r_d.nsp    = push_off;
                r_d.out_cs = r_q.ncs;
                r_d.out_ip = r_q.nip;
                r_d.out_ss = r_q.nss;
                r_d.out_sp = push_off;
                r_d.state  = ST_DONE;
            end
            ST_DONE:  r_d.state = ST_IDLE;
            ST_FAULT: r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.state != ST_IDLE);
    assign done   = (r_q.state == ST_DONE);
    assign fault  = (r_q.state == ST_FAULT);
    assign new_cs = r_q.out_cs;
    assign new_ip = r_q.out_ip;
    assign new_ss = r_q.out_ss;
    assign new_sp = r_q.out_sp;

endmodule

// File: rtl/callgate_seq_chk.sv
module callgate_seq_chk
    import callgate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             fault,
    input logic             mem_req,
    input logic [SEL_W-1:0] new_cs,
    input logic [OFF_W-1:0] new_ip,
    input logic [SEL_W-1:0] new_ss,
    input logic [OFF_W-1:0] new_sp
);
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    a_r9_done_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    a_r3_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_req && $stable(new_cs) && $stable(new_ip)
                   && $stable(new_ss) && $stable(new_sp)));

    a_r9_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || fault));

    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(new_cs) && $stable(new_ip) && $stable(new_ss) && $stable(new_sp)));
endmodule

bind callgate_seq callgate_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .fault   (fault),
    .mem_req (mem_req),
    .new_cs  (new_cs),
    .new_ip  (new_ip),
    .new_ss  (new_ss),
    .new_sp  (new_sp)
);

// File: tb/callgate_seq_bench.sv
module callgate_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] gate_desc = '0;
    logic [1:0]  gate_rpl = '0;
    logic [15:0] cur_cs = '0, cur_ss = '0, tss_sel = 16'h0030;
    logic [31:0] cur_ip = '0, cur_sp = '0;
    logic        busy, done, fault;
    logic [15:0] new_cs, new_ss;
    logic [31:0] new_ip, new_sp;
    logic        mem_req, mem_we, mem_wide;
    logic [15:0] mem_seg;
    logic [31:0] mem_off, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    callgate_seq u_callgate_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .gate_desc(gate_desc),
        .gate_rpl(gate_rpl), .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss),
        .cur_sp(cur_sp), .tss_sel(tss_sel), .busy(busy), .done(done),
        .fault(fault), .new_cs(new_cs), .new_ip(new_ip), .new_ss(new_ss),
        .new_sp(new_sp), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wide(mem_wide), .mem_seg(mem_seg), .mem_off(mem_off),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [logic [47:0]];

    function automatic logic [7:0] rdb(input logic [15:0] s, input logic [31:0] o);
        logic [47:0] k = {s, o};
        return mem.exists(k) ? mem[k] : 8'h00;
    endfunction
    function automatic logic [31:0] rd32(input logic [15:0] s, input logic [31:0] o);
        return {rdb(s, o + 3), rdb(s, o + 2), rdb(s, o + 1), rdb(s, o)};
    endfunction
    function automatic logic [15:0] rd16(input logic [15:0] s, input logic [31:0] o);
        return {rdb(s, o + 1), rdb(s, o)};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                mem[{mem_seg, mem_off}]     = mem_wdata[7:0];
                mem[{mem_seg, mem_off + 1}] = mem_wdata[15:8];
                if (mem_wide) begin
                    mem[{mem_seg, mem_off + 2}] = mem_wdata[23:16];
                    mem[{mem_seg, mem_off + 3}] = mem_wdata[31:24];
                end
            end else begin
                mem_rdata <= mem_wide ? rd32(mem_seg, mem_off)
                                      : {16'h0000, rd16(mem_seg, mem_off)};
            end
        end
    end

    task automatic wr(input logic [15:0] s, input logic [31:0] o, input logic [31:0] v);
        mem[{s, o}] = v[7:0];     mem[{s, o + 1}] = v[15:8];
        mem[{s, o + 2}] = v[23:16]; mem[{s, o + 3}] = v[31:24];
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  typ;
        logic [1:0]  dpl;
        logic        p;
        logic [4:0]  cnt;
        logic [15:0] csel;
        logic [31:0] off;
        logic [15:0] cs;
        logic [31:0] ip;
        logic [15:0] ss;
        logic [31:0] sp;
        logic [1:0]  rpl;
        logic        xfault;
        logic [15:0] xcs;
        logic [31:0] xip;
        logic [15:0] xss;
        logic [31:0] xsp;
        logic [7:0]  xwr;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R5 R4: narrow gate, ring 3 -> ring 0, no parameters
        '{4'h4, 2'd3, 1'b1, 5'd0, 16'h0008, 32'h00001234, 16'h001B, 32'h00000100, 16'h0023, 32'h00000F00, 2'd3,
          1'b0, 16'h0008, 32'h00001234, 16'h0010, 32'h000007F8, 8'd4, 8'd5},
        // R6 R7: wide gate, ring 3 -> ring 1, two parameters
        '{4'hC, 2'd3, 1'b1, 5'd2, 16'h0009, 32'hABCD5678, 16'h001B, 32'h00000100, 16'h0023, 32'h00000F00, 2'd3,
          1'b0, 16'h0009, 32'hABCD5678, 16'h0021, 32'h000005E8, 8'd6, 8'd6},
        // R8: same ring, count ignored
        '{4'h4, 2'd2, 1'b1, 5'd3, 16'h000A, 32'h00002000, 16'h001A, 32'h00000300, 16'h0044, 32'h00000200, 2'd2,
          1'b0, 16'h000A, 32'h00002000, 16'h0044, 32'h000001FC, 8'd2, 8'd8},
        // R3: not present
        '{4'h4, 2'd3, 1'b0, 5'd0, 16'h0008, 32'h00001111, 16'h001B, 32'h00000100, 16'h0023, 32'h00000F00, 2'd3,
          1'b1, 16'h0, 32'h0, 16'h0, 32'h0, 8'd0, 8'd3},
        // R3: CPL above DPL
        '{4'h4, 2'd0, 1'b1, 5'd0, 16'h0008, 32'h00001111, 16'h001B, 32'h00000100, 16'h0023, 32'h00000F00, 2'd0,
          1'b1, 16'h0, 32'h0, 16'h0, 32'h0, 8'd0, 8'd3},
        // R2: bad type
        '{4'h5, 2'd3, 1'b1, 5'd0, 16'h0008, 32'h00001111, 16'h001B, 32'h00000100, 16'h0023, 32'h00000F00, 2'd3,
          1'b1, 16'h0, 32'h0, 16'h0, 32'h0, 8'd0, 8'd2},
        // R3: RPL above DPL
        '{4'h4, 2'd1, 1'b1, 5'd0, 16'h0008, 32'h00001111, 16'h0008, 32'h00000100, 16'h0010, 32'h00000700, 2'd3,
          1'b1, 16'h0, 32'h0, 16'h0, 32'h0, 8'd0, 8'd3},
        // R3: outward target
        '{4'h4, 2'd3, 1'b1, 5'd0, 16'h000A, 32'h00001111, 16'h0019, 32'h00000100, 16'h0021, 32'h00000500, 2'd1,
          1'b1, 16'h0, 32'h0, 16'h0, 32'h0, 8'd0, 8'd3},
        // R7 R6: narrow gate ignores offset high half, one parameter
        '{4'h4, 2'd3, 1'b1, 5'd1, 16'h0008, 32'h5555BEEF, 16'h001B, 32'h0000ABCD, 16'h0023, 32'h00000F00, 2'd3,
          1'b0, 16'h0008, 32'h0000BEEF, 16'h0010, 32'h000007F6, 8'd5, 8'd7}
    };

    logic busy_seen, done_seen, fault_seen, done_after;
    int   nw, done_cnt;

    task automatic run_vec(input vec_t v, input bit poke);
        int w0;
        @(negedge clk);
        gate_desc = {v.off[31:16], v.p, v.dpl, 1'b0, v.typ, 3'b000, v.cnt, v.csel, v.off[15:0]};
        gate_rpl = v.rpl; cur_cs = v.cs; cur_ip = v.ip; cur_ss = v.ss; cur_sp = v.sp;
        start = 1'b1;
        w0 = wr_cnt;
        @(negedge clk);
        start = 1'b0;
        busy_seen = busy;
        done_cnt = 0;
        for (int k = 0; k < 300; k++) begin
            if (done || fault) break;
            if (poke && k == 2) begin
                start = 1'b1;
                gate_desc[47] = 1'b0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        done_seen = done;
        fault_seen = fault;
        @(negedge clk);
        done_after = done;
        nw = wr_cnt - w0;
    endtask

    initial begin
        // task-state slots: ring0 0800/0010, ring1 0600/0021, ring2 0400/0032
        wr(16'h0030, 2, 32'h0010_0800);
        wr(16'h0030, 6, 32'h0021_0600);
        wr(16'h0030, 10, 32'h0032_0400);
        wr(16'h0023, 32'h0F00, 32'h11112222);
        wr(16'h0023, 32'h0F04, 32'h33334444);

        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1", "control idle in reset", {busy, done, fault, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(new_cs == 0 && new_ip == 0 && new_ss == 0 && new_sp == 0, "R1", "results zero",
            {new_cs, new_ss, new_sp}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] pcs, pss;
            logic [31:0] pip, psp;
            string rq;
            vec_t v;
            v = VECS[i];
            rq = $sformatf("R%0d", v.req);
            pcs = new_cs; pip = new_ip; pss = new_ss; psp = new_sp;
            run_vec(v, 1'b0);
            chk(busy_seen, "R9", "busy after start", busy_seen, 1);
            chk(nw == int'(v.xwr), rq, "write count", nw, v.xwr);
            if (v.xfault) begin
                chk(fault_seen && !done_seen, rq, "fault raised", {fault_seen, done_seen}, 2'b10);
                chk(new_cs == pcs && new_ip == pip && new_ss == pss && new_sp == psp,
                    rq, "results unchanged after fault", {new_cs, new_ip}, {pcs, pip});
            end else begin
                chk(done_seen && !fault_seen, rq, "done raised", {done_seen, fault_seen}, 2'b10);
                chk(!done_after, "R9", "done is one cycle", done_after, 0);
                chk(new_cs == v.xcs, rq, "new_cs", new_cs, v.xcs);
                chk(new_ip == v.xip, rq, "new_ip", new_ip, v.xip);
                chk(new_ss == v.xss, rq, "new_ss", new_ss, v.xss);
                chk(new_sp == v.xsp, rq, "new_sp", new_sp, v.xsp);
            end
        end

        // R5 R6: wide frame on ring-1 stack (segment 0021)
        chk(rd32(16'h0021, 32'h05FC) == 32'h23, "R5", "old SS slot", rd32(16'h0021, 32'h05FC), 32'h23);
        chk(rd32(16'h0021, 32'h05F8) == 32'hF00, "R5", "old SP slot", rd32(16'h0021, 32'h05F8), 32'hF00);
        chk(rd32(16'h0021, 32'h05F4) == 32'h33334444, "R6", "param 1 slot", rd32(16'h0021, 32'h05F4), 32'h33334444);
        chk(rd32(16'h0021, 32'h05F0) == 32'h11112222, "R6", "param 0 slot", rd32(16'h0021, 32'h05F0), 32'h11112222);
        chk(rd32(16'h0021, 32'h05EC) == 32'h1B, "R5", "old CS slot", rd32(16'h0021, 32'h05EC), 32'h1B);
        chk(rd32(16'h0021, 32'h05E8) == 32'h100, "R5", "old IP slot", rd32(16'h0021, 32'h05E8), 32'h100);
        // R7: narrow frame on ring-0 stack (segment 0010), last run wins
        chk(rd16(16'h0010, 32'h07FE) == 16'h23, "R7", "narrow old SS", rd16(16'h0010, 32'h07FE), 16'h23);
        chk(rd16(16'h0010, 32'h07FA) == 16'h2222, "R7", "narrow param", rd16(16'h0010, 32'h07FA), 16'h2222);
        chk(rd16(16'h0010, 32'h07F6) == 16'hABCD, "R7", "narrow old IP", rd16(16'h0010, 32'h07F6), 16'hABCD);
        // R8: same-ring frame on current stack (segment 0044)
        chk(rd16(16'h0044, 32'h01FE) == 16'h1A, "R8", "same-ring CS", rd16(16'h0044, 32'h01FE), 16'h1A);
        chk(rd16(16'h0044, 32'h01FC) == 16'h300, "R8", "same-ring IP", rd16(16'h0044, 32'h01FC), 16'h300);

        // R10: a faulting start pulsed mid-sequence must be ignored
        run_vec(VECS[1], 1'b1);
        chk(done_seen && !fault_seen, "R10", "run completes despite start", {done_seen, fault_seen}, 2'b10);
        chk(new_sp == 32'h05E8, "R10", "result unaffected", new_sp, 32'h05E8);
        repeat (3) @(negedge clk);
        chk(!busy && !fault, "R10", "no second sequence", {busy, fault}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule